// File: doc/BRIEF.md
# Multi-Mode Countdown Timer with Watchdog Reset

This block is one timer channel. A 16-bit counter counts down by one on each pulse from its own power-of-two clock divider. When a count runs out, the channel raises a sticky interrupt and refills the counter. How it refills, and whether it keeps running, depends on the selected mode: periodic, one-shot, free-running or watchdog.

Firmware drives the channel through a small write-only register port:
- LOAD sets the reload value and also copies it straight into the counter. In watchdog mode this write is the "kick".
- CTRL sets the mode, the enable bit and the divider exponent.
- STATUS clears the interrupt and the watchdog flag.

In watchdog mode, an expiry sends a one-cycle request to the chip reset logic. It also sets a sticky flag. The system reset input does not clear that flag, so boot firmware can read why the chip restarted. Only the power-on reset input or a firmware clear removes it.

Top module: `cdt_timer`

## Requirements
- R1: CTRL (address 1) holds the mode in bits [1:0], the enable in bit 2 and the divider exponent P in bits [7:4]. While the timer is running, the counter steps down once every 2^P clocks. The first step comes 2^P clocks after the clock edge that enables it.
- R2: A LOAD write (address 0) stores the value and copies it into the counter at the same edge, in every mode. It takes priority over a step or an expiry in that cycle, so it acts as the watchdog kick.
- R3: Periodic mode (code 0) works as follows. A step taken while the counter is at 1 (or 0) is an expiry. An expiry sets the interrupt and reloads the LOAD value, so the interrupt period equals LOAD steps.
- R4: One-shot mode (code 1) expires like periodic mode, reloads the LOAD value and clears the enable bit, so counting stops.
- R5: Free-running mode (code 2) reloads 16'hFFFF on expiry. A LOAD write in this mode still sets the counter once, but later reloads use 16'hFFFF.
- R6: Setting the enable bit makes counting resume from the counter's present value. Clearing it freezes the counter.
- R7: In every mode other than free-running, a LOAD value of zero keeps the channel stopped: the counter does not change and no interrupt is raised.
- R8: In watchdog mode (code 3), an expiry raises the reset request `wdt_req_o` for exactly one cycle, sets the watchdog flag, sets the interrupt and reloads the LOAD value.
- R9: The watchdog flag is unchanged by `sys_rst_i`. It is cleared by `por_i` or by a STATUS write (address 2) with bit 1 set. An expiry in the same cycle as that write wins.
- R10: The interrupt stays set until a STATUS write with bit 0 set. `sys_rst_i` and `por_i` clear the counter, the LOAD value, the control fields, the interrupt and the reset request to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous for the watchdog flag |
| sys_rst_i | input | 1 | Chip reset, active high, synchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 LOAD, 1 CTRL, 2 STATUS |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Present counter value |
| enable_o | output | 1 | Present enable bit |
| irq_o | output | 1 | Sticky interrupt |
| wdt_req_o | output | 1 | One-cycle chip reset request |
| wdt_flag_o | output | 1 | Sticky watchdog expiry flag |

## Verification
The assertions assume the following about the inputs:
- `por_i` is high from time zero until the first clock edges have passed.
- Writes last one cycle and use only the three defined addresses.
- The reset inputs are held inactive while the counting properties are judged. Those properties are disabled while either reset is high.

The stimulus drives every input on the falling clock edge. It issues writes back to back, without idle gaps, so each expected counter value follows directly from counting rising edges. It raises `sys_rst_i` only after a watchdog request, mimicking the chip reset tree.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    MODE_PERIODIC = 2'd0,
    MODE_ONESHOT  = 2'd1,
    MODE_FREE     = 2'd2,
    MODE_WDOG     = 2'd3
  } mode_e;

  localparam logic [1:0] ADDR_LOAD = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int CTRL_EN_BIT   = 2;
  localparam int CTRL_PS_LSB   = 4;
  localparam int STAT_IRQ_BIT  = 0;
  localparam int STAT_FLAG_BIT = 1;
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int PRE_W  = 16,
  parameter int PSEL_W = $clog2(PRE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              tick_o
);
  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] mask;

  assign mask   = (PRE_W'(1) << psel_i) - PRE_W'(1);
  assign tick_o = run_i && ((pcnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run_i) pcnt_q <= '0;
    else               pcnt_q <= pcnt_q + PRE_W'(1);
  end

  // R1: with a divider above one, two ticks never fall on adjacent cycles
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick_o && psel_i != '0) |=> (!tick_o || psel_i == '0));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
  import cdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  mode_e            mode_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             ld_wr_i,
  input  logic [CNT_W-1:0] ld_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] reload;

  assign expire_o = tick_i && !ld_wr_i && (count_q <= CNT_W'(1));
  assign reload   = (mode_i == MODE_FREE) ? '1 : load_i;
  assign count_o  = count_q;

  always_ff @(posedge clk) begin
    if (rst)           count_q <= '0;
    else if (ld_wr_i)  count_q <= ld_data_i;
    else if (expire_o) count_q <= reload;
    else if (tick_i)   count_q <= count_q - CNT_W'(1);
  end

  // R1: an ordinary tick lowers the count by exactly one
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !ld_wr_i && count_q > CNT_W'(1)) |=> (count_q == $past(count_q) - CNT_W'(1)));

  // R5: free-running expiry lands on all ones
  a_r5_free_reload: assert property (@(posedge clk) disable iff (rst)
    (expire_o && mode_i == MODE_FREE) |=> (count_q == {CNT_W{1'b1}}));

  // R7: zero load outside free-running mode leaves the counter frozen
  a_r7_zero_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_i != MODE_FREE && load_i == '0 && !ld_wr_i) |=> $stable(count_q));

  // R2: a load write always lands in the counter
  a_r2_load_copy: assert property (@(posedge clk) disable iff (rst)
    ld_wr_i |=> (count_q == $past(ld_data_i)));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             por_i,
  input  logic             sys_rst_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             enable_o,
  output logic             irq_o,
  output logic             wdt_req_o,
  output logic             wdt_flag_o
);
  localparam int PSEL_W = $clog2(PRE_W);
  localparam int PS_MSB = CTRL_PS_LSB + PSEL_W - 1;

  logic              rst;
  logic              wr_load, wr_ctrl, wr_stat;
  logic [CNT_W-1:0]  load_q;
  mode_e             mode_q;
  logic              en_q;
  logic [PSEL_W-1:0] psel_q;
  logic              irq_q, req_q, flag_q;
  logic              run, tick, expire, wd_expire;
  logic [CNT_W-1:0]  count;

  assign rst       = sys_rst_i | por_i;
  assign wr_load   = wr_en_i && (wr_addr_i == ADDR_LOAD);
  assign wr_ctrl   = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_stat   = wr_en_i && (wr_addr_i == ADDR_STAT);
  assign run       = en_q && ((mode_q == MODE_FREE) || (load_q != '0));
  assign wd_expire = expire && (mode_q == MODE_WDOG);

  cdt_prescaler #(.PRE_W(PRE_W), .PSEL_W(PSEL_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .psel_i (psel_q),
    .tick_o (tick)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .mode_i    (mode_q),
    .load_i    (load_q),
    .ld_wr_i   (wr_load),
    .ld_data_i (wr_data_i),
    .count_o   (count),
    .expire_o  (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
      mode_q <= MODE_PERIODIC;
      en_q   <= 1'b0;
      psel_q <= '0;
    end else begin
      if (wr_load) load_q <= wr_data_i;
      if (wr_ctrl) begin
        mode_q <= mode_e'(wr_data_i[1:0]);
        en_q   <= wr_data_i[CTRL_EN_BIT];
        psel_q <= wr_data_i[PS_MSB:CTRL_PS_LSB];
      end else if (expire && mode_q == MODE_ONESHOT) begin
        en_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      req_q <= wd_expire;
      if (expire)                               irq_q <= 1'b1;
      else if (wr_stat && wr_data_i[STAT_IRQ_BIT]) irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)                                  flag_q <= 1'b0;
    else if (wd_expire)                         flag_q <= 1'b1;
    else if (wr_stat && wr_data_i[STAT_FLAG_BIT]) flag_q <= 1'b0;
  end

  assign count_o    = count;
  assign enable_o   = en_q;
  assign irq_o      = irq_q;
  assign wdt_req_o  = req_q;
  assign wdt_flag_o = flag_q;

  // R8: the reset request lasts one cycle
  a_r8_req_pulse: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);

  // R8: a request is always accompanied by the flag
  a_r8_flag_with_req: assert property (@(posedge clk) disable iff (rst)
    req_q |-> flag_q);

  // R4: one-shot expiry drops the enable
  a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
    (expire && mode_q == MODE_ONESHOT && !wr_ctrl) |=> !en_q);

  // R10: the interrupt holds until cleared
  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !(wr_stat && wr_data_i[STAT_IRQ_BIT])) |=> irq_q);

  // R9: a chip reset leaves the flag alone
  a_r9_flag_survives: assert property (@(posedge clk) disable iff (por_i)
    (sys_rst_i && flag_q) |=> flag_q);

  // R10: a chip reset clears counter and interrupt
  a_r10_sysrst_clears: assert property (@(posedge clk) disable iff (por_i)
    sys_rst_i |=> (!irq_q && count == '0 && !en_q));
endmodule

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        por_i = 1'b1;
  logic        sys_rst_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = 2'd0;
  logic [15:0] wr_data_i = 16'd0;
  logic [15:0] count_o;
  logic        enable_o, irq_o, wdt_req_o, wdt_flag_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdt_timer u_dut (
    .clk        (clk),
    .por_i      (por_i),
    .sys_rst_i  (sys_rst_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .count_o    (count_o),
    .enable_o   (enable_o),
    .irq_o      (irq_o),
    .wdt_req_o  (wdt_req_o),
    .wdt_flag_o (wdt_flag_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; consumes exactly one rising edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 count after reset", count_o, 0);
    chk("R10 irq after reset", irq_o, 0);
    chk("R10 enable after reset", enable_o, 0);
    chk("R9 flag after por", wdt_flag_o, 0);
    chk("R8 req after reset", wdt_req_o, 0);
  endtask

  task automatic t_periodic;
    wr(2'd0, 16'd3);
    chk("R2 load copied", count_o, 3);
    wr(2'd1, 16'h0004);
    chk("R1 no step at enable edge", count_o, 3);
    step(1); chk("R1 first step", count_o, 2);
    step(1); chk("R3 count one", count_o, 1);
    chk("R3 no irq before expiry", irq_o, 0);
    step(1); chk("R3 reload", count_o, 3);
    chk("R3 irq set", irq_o, 1);
    step(1); chk("R10 irq sticky", irq_o, 1);
    wr(2'd2, 16'h0001);
    chk("R10 irq cleared", irq_o, 0);
    chk("R3 still counting", count_o, 1);
    step(1); chk("R3 second expiry irq", irq_o, 1);
    chk("R3 second reload", count_o, 3);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0001);
  endtask

  task automatic t_prescale;
    wr(2'd0, 16'd2);
    wr(2'd1, 16'h0024);
    step(3); chk("R1 held before 4 clocks", count_o, 2);
    step(1); chk("R1 step after 4 clocks", count_o, 1);
    step(3); chk("R1 held in second window", count_o, 1);
    chk("R1 no early irq", irq_o, 0);
    step(1); chk("R1 expiry after 8 clocks", irq_o, 1);
    chk("R3 reload with divider", count_o, 2);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0001);
  endtask

  task automatic t_oneshot;
    wr(2'd0, 16'd2);
    wr(2'd1, 16'h0005);
    step(1); chk("R4 step", count_o, 1);
    step(1); chk("R4 irq", irq_o, 1);
    chk("R4 reload", count_o, 2);
    chk("R4 enable cleared", enable_o, 0);
    step(4); chk("R4 stopped", count_o, 2);
    wr(2'd2, 16'h0001);
  endtask

  task automatic t_zero;
    wr(2'd0, 16'd0);
    wr(2'd1, 16'h0004);
    step(6);
    chk("R7 periodic zero load frozen", count_o, 0);
    chk("R7 periodic zero load no irq", irq_o, 0);
    wr(2'd1, 16'h0007);
    step(4);
    chk("R7 watchdog zero load no request", wdt_flag_o, 0);
    chk("R7 watchdog zero load frozen", count_o, 0);
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_resume;
    wr(2'd0, 16'd10);
    wr(2'd1, 16'h0004);
    step(4); chk("R6 running", count_o, 6);
    wr(2'd1, 16'h0000);
    chk("R6 last step at disable edge", count_o, 5);
    step(3); chk("R6 frozen while disabled", count_o, 5);
    wr(2'd1, 16'h0004);
    chk("R6 no jump on enable", count_o, 5);
    step(2); chk("R6 resumes from present value", count_o, 3);
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_free;
    wr(2'd0, 16'd3);
    wr(2'd1, 16'h0006);
    step(3); chk("R5 reload all ones", count_o, 16'hFFFF);
    chk("R5 irq", irq_o, 1);
    step(1); chk("R5 keeps counting", count_o, 16'hFFFE);
    wr(2'd0, 16'd5);
    chk("R5 load taken once", count_o, 5);
    step(5); chk("R5 later reload ignores load", count_o, 16'hFFFF);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0001);
  endtask

  task automatic t_watchdog;
    wr(2'd0, 16'd4);
    wr(2'd1, 16'h0007);
    step(2); chk("R8 counting", count_o, 2);
    wr(2'd0, 16'd4);
    chk("R2 kick restarts", count_o, 4);
    step(3); chk("R8 no request before zero", wdt_req_o, 0);
    chk("R8 count one", count_o, 1);
    step(1); chk("R8 request", wdt_req_o, 1);
    chk("R8 flag set", wdt_flag_o, 1);
    chk("R8 irq set", irq_o, 1);
    step(1); chk("R8 request one cycle", wdt_req_o, 0);
    sys_rst_i = 1'b1;
    @(negedge clk);
    sys_rst_i = 1'b0;
    chk("R9 flag survives chip reset", wdt_flag_o, 1);
    chk("R10 count cleared by chip reset", count_o, 0);
    chk("R10 irq cleared by chip reset", irq_o, 0);
    chk("R10 enable cleared by chip reset", enable_o, 0);
    wr(2'd2, 16'h0002);
    chk("R9 firmware clear", wdt_flag_o, 0);
    wr(2'd0, 16'd1);
    wr(2'd1, 16'h0007);
    step(1); chk("R9 flag set again", wdt_flag_o, 1);
    por_i = 1'b1;
    @(negedge clk);
    chk("R9 por clears flag", wdt_flag_o, 0);
    chk("R10 por clears count", count_o, 0);
    por_i = 1'b0;
    step(1);
  endtask

  initial begin
    step(3);
    por_i = 1'b0;
    step(1);
    t_reset();
    t_periodic();
    t_prescale();
    t_oneshot();
    t_zero();
    t_resume();
    t_free();
    t_watchdog();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule